// File: doc/BRIEF.md
# Attribute and Color Index Pipeline

This block turns a stream of display pixels into 8-bit indices for an external color palette. Each clock may carry one pixel. In text mode the pixel comes from a glyph bit and an 8-bit attribute code. In the 16-color graphics mode it comes from a 4-bit value. Either way a 4-bit value selects one of sixteen programmable 6-bit lookup entries, and two programmable high bits are placed above the result. In the paired 256-color mode, two successive 4-bit lookups are packed into one byte. In the direct 256-color mode an 8-bit value passes straight through, and the lookup table is not used.

Text mode also applies attribute blink, cursor blink and underline. A panning setting delays the whole pixel stream by 0 to 7 clocks. The lookup entries are loaded through a simple write port. Mode, high bits, panning and the blink controls are static configuration inputs driven by the surrounding display logic.

Top module: `attr_color_pipe`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `out_index` are 0 and all sixteen lookup entries read as 0.
- R2: In mode 1 (16-color graphics), a valid pixel with value n produces `out_index = {hi_bits, entry[n]}`.
- R3: In mode 0 (text) with `blink_en` = 0, a glyph bit of 1 selects the foreground nibble `attr_code[3:0]` and a glyph bit of 0 selects the background nibble `attr_code[7:4]`. The selected nibble then goes through the lookup as in R2.
- R4: With `blink_en` = 1, the background nibble is `{0, attr_code[6:4]}` and `attr_code[7]` marks the character as blinking. A blinking character with `blink_phase` = 0 shows the background on every pixel, whatever the glyph, underline or cursor inputs say.
- R5: In text mode, `underline` = 1 makes the pixel foreground, as a glyph bit of 1 would.
- R6: In text mode, `cursor_hit` = 1 together with `cursor_phase` = 1 inverts the foreground/background choice after underline has been applied. R4 overrides this.
- R7: In mode 2 (paired), two consecutive valid pixels a then b give one output `{entry[a][3:0], entry[b][3:0]}`, and `out_valid` rises only on the second pixel. Any cycle that is not in mode 2 restarts the pairing.
- R8: In mode 3 (direct), a valid pixel gives `out_index = pix_raw`, whatever the lookup entries hold.
- R9: A valid pixel sampled at clock edge e appears at the outputs after edge e+1+pan. A cycle with `in_valid` = 0 produces `out_valid` = 0 at the corresponding edge.
- R10: `pan` (0 to 7) adds exactly `pan` clocks of delay to the stream, and all modes are delayed alike.
- R11: A write to the lookup changes it from the next edge on. A lookup taking place at the same edge as a write to that entry uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 text, 1 16-color, 2 paired 256-color, 3 direct 256-color |
| hi_bits | input | 2 | Upper index bits used in modes 0 and 1 |
| pan | input | 3 | Panning delay in pixels |
| blink_en | input | 1 | Treat attribute bit 7 as blink instead of a background bit |
| blink_phase | input | 1 | Character blink phase, 1 = visible |
| cursor_phase | input | 1 | Cursor blink phase, 1 = cursor shown |
| lut_we | input | 1 | Lookup entry write strobe |
| lut_waddr | input | 4 | Entry to write |
| lut_wdata | input | 6 | Value to write |
| in_valid | input | 1 | Pixel present this clock |
| pix_nib | input | 4 | Pixel value in mode 1 and mode 2 |
| pix_raw | input | 8 | Pixel byte in mode 3 |
| glyph_bit | input | 1 | Font pattern bit in mode 0 |
| attr_code | input | 8 | Character attribute in mode 0 |
| underline | input | 1 | Pixel is on the underline row |
| cursor_hit | input | 1 | Pixel lies inside the cursor |
| out_valid | output | 1 | `out_index` carries a new value |
| out_index | output | 8 | Palette index |

## Verification
Two functions can meet in one cycle: a lookup-table write and the lookup of the same entry, and the blink override and underline/cursor on the same text pixel. The collision is provoked by placing a pixel so that its lookup edge is the very edge at which its entry is rewritten. The pixel must then show the old value, and the pixel that follows must show the new one. The attribute sweeps drive underline and cursor together with every blink phase and attribute code. Each output is judged against an index computed arithmetically from the attribute and the bench's own copy of the table.

// File: rtl/acp_pkg.sv
// Shared widths, mode encoding and the pixel record that travels down
// the pipeline. Assumes 4-bit pixel values and an index of two nibbles.
package acp_pkg;
    localparam int NIB_W     = 4;
    localparam int IDX_W     = 2 * NIB_W;
    localparam int LUT_DEPTH = 1 << NIB_W;

    typedef enum logic [1:0] {
        MODE_TEXT    = 2'd0,
        MODE_PLANAR  = 2'd1,
        MODE_PAIR    = 2'd2,
        MODE_DIRECT  = 2'd3
    } acp_mode_e;

    typedef struct packed {
        logic             vld;
        logic [NIB_W-1:0] nib;
        logic [IDX_W-1:0] raw;
    } acp_pix_t;
endpackage

// File: rtl/acp_resolve.sv
// Stage 1: forms the 4-bit lookup selector for each pixel. In text mode
// it chooses the foreground or background attribute nibble from the glyph,
// underline, cursor and blink inputs. In the other modes it forwards the
// pixel nibble. The raw byte is always carried for direct mode.
// Assumes the configuration inputs are stable while pixels flow.
module acp_resolve
    import acp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  acp_mode_e        mode,
    input  logic             blink_en,
    input  logic             blink_phase,
    input  logic             cursor_phase,
    input  logic             in_valid,
    input  logic [NIB_W-1:0] pix_nib,
    input  logic [IDX_W-1:0] pix_raw,
    input  logic             glyph_bit,
    input  logic [IDX_W-1:0] attr_code,
    input  logic             underline,
    input  logic             cursor_hit,
    output acp_pix_t         pix_q
);
    logic             show_fg;
    logic [NIB_W-1:0] fg_nib;
    logic [NIB_W-1:0] bg_nib;
    acp_pix_t         pix_d;

    // Picks the nibble to be looked up for the current pixel.
    always_comb begin
        fg_nib  = attr_code[NIB_W-1:0];
        bg_nib  = blink_en ? {1'b0, attr_code[IDX_W-2:NIB_W]}
                           : attr_code[IDX_W-1:NIB_W];
        show_fg = (glyph_bit | underline) ^ (cursor_hit & cursor_phase);
        if (blink_en && attr_code[IDX_W-1] && !blink_phase) begin
            show_fg = 1'b0;
        end
        pix_d.vld = in_valid;
        pix_d.raw = pix_raw;
        pix_d.nib = (mode == MODE_TEXT) ? (show_fg ? fg_nib : bg_nib) : pix_nib;
    end

    // Registers the resolved pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    AST_BLINK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_TEXT && blink_en && attr_code[IDX_W-1] && !blink_phase)
        |=> (pix_q.nib == {1'b0, $past(attr_code[IDX_W-2:NIB_W])}))
        else $error("blink off phase did not show background"); // R4

    AST_UNDERLINE_FG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_TEXT && underline && !cursor_hit && !blink_en)
        |=> (pix_q.nib == $past(attr_code[NIB_W-1:0])))
        else $error("underline pixel not foreground"); // R5
endmodule

// File: rtl/acp_pan_line.sv
// Panning delay: keeps the last DEPTH-1 pixel records and selects the one
// that lies 'pan' clocks back; pan = 0 passes the current record through.
// Assumes pan is changed only when a glitch in the stream is acceptable.
module acp_pan_line
    import acp_pkg::*;
#(
    parameter int PAN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAN_W-1:0] pan,
    input  acp_pix_t         din,
    output acp_pix_t         dout
);
    localparam int DEPTH = 1 << PAN_W;

    acp_pix_t hist [DEPTH-1];
    acp_pix_t taps [DEPTH];

    assign taps[0] = din;

    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_hist
        // Shifts one record per clock into history slot k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist[k] <= '0;
            end else if (k == 0) begin
                hist[k] <= din;
            end else begin
                hist[k] <= hist[(k == 0) ? 0 : k - 1];
            end
        end
        assign taps[k + 1] = hist[k];
    end

    assign dout = taps[pan];
endmodule

// File: rtl/acp_index_form.sv
// Stage 2: holds the sixteen lookup entries and forms the palette index for
// each mode: high bits above the entry, two entry nibbles paired, or the raw
// byte. A write lands at the clock edge; a lookup at that same edge sees the
// old entry. Assumes LUT_W >= NIB_W and LUT_W < IDX_W.
module acp_index_form
    import acp_pkg::*;
#(
    parameter int LUT_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  acp_mode_e              mode,
    input  logic [IDX_W-LUT_W-1:0] hi_bits,
    input  acp_pix_t               pix,
    input  logic                   lut_we,
    input  logic [NIB_W-1:0]       lut_waddr,
    input  logic [LUT_W-1:0]       lut_wdata,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_index
);
    logic [LUT_W-1:0] lut_q [LUT_DEPTH];
    logic [LUT_W-1:0] look;
    logic             pair_phase;
    logic [NIB_W-1:0] pair_hold;
    logic             nxt_valid;
    logic [IDX_W-1:0] nxt_index;
    logic             nxt_phase;
    logic [NIB_W-1:0] nxt_hold;

    for (genvar e = 0; e < LUT_DEPTH; e++) begin : g_lut
        // Stores lookup entry e from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lut_q[e] <= '0;
            end else if (lut_we && lut_waddr == NIB_W'(e)) begin
                lut_q[e] <= lut_wdata;
            end
        end
    end

    // Computes the next output and pairing state for the incoming pixel.
    always_comb begin
        look      = lut_q[pix.nib];
        nxt_valid = 1'b0;
        nxt_index = out_index;
        nxt_phase = pair_phase;
        nxt_hold  = pair_hold;
        unique case (mode)
            MODE_TEXT, MODE_PLANAR: begin
                nxt_phase = 1'b0;
                if (pix.vld) begin
                    nxt_valid = 1'b1;
                    nxt_index = {hi_bits, look};
                end
            end
            MODE_PAIR: begin
                if (pix.vld) begin
                    if (!pair_phase) begin
                        nxt_hold  = look[NIB_W-1:0];
                        nxt_phase = 1'b1;
                    end else begin
                        nxt_valid = 1'b1;
                        nxt_index = {pair_hold, look[NIB_W-1:0]};
                        nxt_phase = 1'b0;
                    end
                end
            end
            MODE_DIRECT: begin
                nxt_phase = 1'b0;
                if (pix.vld) begin
                    nxt_valid = 1'b1;
                    nxt_index = pix.raw;
                end
            end
        endcase
    end

    // Registers the output and the pairing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_index  <= '0;
            pair_phase <= 1'b0;
            pair_hold  <= '0;
        end else begin
            out_valid  <= nxt_valid;
            out_index  <= nxt_index;
            pair_phase <= nxt_phase;
            pair_hold  <= nxt_hold;
        end
    end

    AST_LUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        lut_we |=> (lut_q[$past(lut_waddr)] == $past(lut_wdata)))
        else $error("lookup entry not written"); // R11

    AST_HI_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix.vld && (mode == MODE_TEXT || mode == MODE_PLANAR))
        |=> (out_index[IDX_W-1:LUT_W] == $past(hi_bits)))
        else $error("high index bits wrong"); // R2

    AST_PAIR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAIR && out_valid) |=> !out_valid)
        else $error("paired mode gave back-to-back outputs"); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pix.vld |=> !out_valid)
        else $error("output without pixel"); // R9
endmodule

// File: rtl/attr_color_pipe.sv
// Top: attribute resolve -> panning delay -> lookup and index formation.
// Latency is 2 + pan clocks from input to output. Assumes mode, hi_bits,
// pan and blink_en are held steady while a stream is in flight.
module attr_color_pipe
    import acp_pkg::*;
#(
    parameter int LUT_W = 6,
    parameter int PAN_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic [IDX_W-LUT_W-1:0] hi_bits,
    input  logic [PAN_W-1:0]       pan,
    input  logic                   blink_en,
    input  logic                   blink_phase,
    input  logic                   cursor_phase,
    input  logic                   lut_we,
    input  logic [NIB_W-1:0]       lut_waddr,
    input  logic [LUT_W-1:0]       lut_wdata,
    input  logic                   in_valid,
    input  logic [NIB_W-1:0]       pix_nib,
    input  logic [IDX_W-1:0]       pix_raw,
    input  logic                   glyph_bit,
    input  logic [IDX_W-1:0]       attr_code,
    input  logic                   underline,
    input  logic                   cursor_hit,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_index
);
    acp_mode_e mode_e;
    acp_pix_t  res_pix;
    acp_pix_t  pan_pix;

    assign mode_e = acp_mode_e'(mode);

    acp_resolve u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_e),
        .blink_en     (blink_en),
        .blink_phase  (blink_phase),
        .cursor_phase (cursor_phase),
        .in_valid     (in_valid),
        .pix_nib      (pix_nib),
        .pix_raw      (pix_raw),
        .glyph_bit    (glyph_bit),
        .attr_code    (attr_code),
        .underline    (underline),
        .cursor_hit   (cursor_hit),
        .pix_q        (res_pix)
    );

    acp_pan_line #(.PAN_W(PAN_W)) u_pan (
        .clk   (clk),
        .rst_n (rst_n),
        .pan   (pan),
        .din   (res_pix),
        .dout  (pan_pix)
    );

    acp_index_form #(.LUT_W(LUT_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .hi_bits   (hi_bits),
        .pix       (pan_pix),
        .lut_we    (lut_we),
        .lut_waddr (lut_waddr),
        .lut_wdata (lut_wdata),
        .out_valid (out_valid),
        .out_index (out_index)
    );
endmodule

// File: tb/tb_attr_color_pipe.sv
module tb_attr_color_pipe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd1;
    logic [1:0] hi_bits = 2'd0;
    logic [2:0] pan = 3'd0;
    logic       blink_en = 1'b0, blink_phase = 1'b0, cursor_phase = 1'b0;
    logic       lut_we = 1'b0;
    logic [3:0] lut_waddr = 4'd0;
    logic [5:0] lut_wdata = 6'd0;
    logic       in_valid = 1'b0;
    logic [3:0] pix_nib = 4'd0;
    logic [7:0] pix_raw = 8'd0;
    logic       glyph_bit = 1'b0;
    logic [7:0] attr_code = 8'd0;
    logic       underline = 1'b0, cursor_hit = 1'b0;
    logic       out_valid;
    logic [7:0] out_index;

    attr_color_pipe dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int    nchk = 0, nfail = 0, cyc = 0;
    bit    sb_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // Bench-side model state
    logic       rec_vld [16];
    logic [3:0] rec_nib [16];
    logic [7:0] rec_raw [16];
    logic [5:0] mlut [16];
    logic       mphase, exp_vld;
    logic [3:0] mhold;
    logic [7:0] exp_idx;
    int         slot, tapi;

    // Text pixel selector, from R3 to R6
    function automatic logic [3:0] f_text(logic g, logic ul, logic ch, logic cp,
                                          logic [7:0] a, logic be, logic bp);
        logic       fg_on;
        logic [3:0] bg;
        fg_on = (g | ul) ^ (ch & cp);
        bg    = be ? {1'b0, a[6:4]} : a[7:4];
        if (be && a[7] && !bp) fg_on = 1'b0;
        return fg_on ? a[3:0] : bg;
    endfunction

    // Expected output per edge: a pixel sampled at edge e is looked up at edge e+1+pan
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) begin
                rec_vld[k] = 1'b0; rec_nib[k] = 4'd0; rec_raw[k] = 8'd0; mlut[k] = 6'd0;
            end
            mphase = 1'b0; mhold = 4'd0; exp_vld = 1'b0; exp_idx = 8'd0;
        end else begin
            slot = cyc & 15;
            rec_vld[slot] = in_valid;
            rec_raw[slot] = pix_raw;
            rec_nib[slot] = (mode == 2'd0)
                ? f_text(glyph_bit, underline, cursor_hit, cursor_phase, attr_code, blink_en, blink_phase)
                : pix_nib;
            tapi = (cyc + 15 - int'(pan)) & 15;
            exp_vld = 1'b0;
            case (mode)
                2'd0, 2'd1: begin
                    mphase = 1'b0;
                    if (rec_vld[tapi]) begin exp_vld = 1'b1; exp_idx = {hi_bits, mlut[rec_nib[tapi]]}; end
                end
                2'd2: if (rec_vld[tapi]) begin
                    if (!mphase) begin mhold = mlut[rec_nib[tapi]][3:0]; mphase = 1'b1; end
                    else begin exp_vld = 1'b1; exp_idx = {mhold, mlut[rec_nib[tapi]][3:0]}; mphase = 1'b0; end
                end
                default: begin
                    mphase = 1'b0;
                    if (rec_vld[tapi]) begin exp_vld = 1'b1; exp_idx = rec_raw[tapi]; end
                end
            endcase
            if (lut_we) mlut[lut_waddr] = lut_wdata;   // write after lookup: R11
        end
        cyc++;
    end

    // Scoreboard, sampled at the falling edge
    always @(negedge clk) begin
        if (sb_on && !done) begin
            nchk++;
            if (out_valid !== exp_vld || (exp_vld && out_index !== exp_idx)) begin
                nfail++;
                $display("FAIL %s: valid=%0b index=%02h expected valid=%0b index=%02h",
                         cur_req, out_valid, out_index, exp_vld, exp_idx);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); in_valid = 1'b0; lut_we = 1'b0; end
    endtask

    task automatic pix(logic [3:0] n);
        @(negedge clk); in_valid = 1'b1; pix_nib = n; lut_we = 1'b0;
    endtask

    task automatic txt(logic g, logic [7:0] a);
        @(negedge clk); in_valid = 1'b1; glyph_bit = g; attr_code = a; lut_we = 1'b0;
    endtask

    task automatic wr(logic [3:0] a, logic [5:0] d);
        @(negedge clk); lut_we = 1'b1; lut_waddr = a; lut_wdata = d; in_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        nchk++;
        if (out_valid !== 1'b0 || out_index !== 8'h00) begin
            nfail++;
            $display("FAIL R1: valid=%0b index=%02h expected valid=0 index=00", out_valid, out_index);
        end
        rst_n = 1'b1;
        sb_on = 1'b1;

        // R1: entries read as zero before any write -> {hi_bits, 000000}
        cur_req = "R1"; mode = 2'd1; hi_bits = 2'd2;
        for (int n = 0; n < 16; n++) pix(4'(n));
        idle(12);

        for (int i = 0; i < 16; i++) wr(4'(i), 6'((i * 13 + 5) & 63));
        idle(2);

        // R2: every value with every high-bit setting
        cur_req = "R2";
        for (int h = 0; h < 4; h++) begin
            hi_bits = 2'(h);
            for (int n = 0; n < 16; n++) pix(4'(n));
        end
        idle(12);

        // R3: every attribute, both glyph values, no blink
        cur_req = "R3"; mode = 2'd0; hi_bits = 2'd1;
        for (int a = 0; a < 256; a++) begin txt(1'b0, 8'(a)); txt(1'b1, 8'(a)); end
        idle(12);

        // R4: blink enabled, both phases
        cur_req = "R4"; blink_en = 1'b1;
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 4; k++) begin blink_phase = k[1]; txt(k[0], 8'(a)); end
        blink_phase = 1'b1;
        idle(12);

        // R5: underline, with and without blink (blink off phase wins)
        cur_req = "R5"; underline = 1'b1;
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 4; k++) begin blink_en = k[1]; blink_phase = k[0]; txt(1'b0, 8'(a)); end
        underline = 1'b0; blink_en = 1'b0; blink_phase = 1'b1;
        idle(12);

        // R6: cursor inversion combined with underline and blink
        cur_req = "R6"; cursor_hit = 1'b1;
        for (int a = 0; a < 256; a += 7)
            for (int k = 0; k < 32; k++) begin
                underline = k[1]; cursor_phase = k[2]; blink_en = k[3]; blink_phase = k[4];
                txt(k[0], 8'(a));
            end
        cursor_hit = 1'b0; underline = 1'b0; blink_en = 1'b0; cursor_phase = 1'b0;
        idle(12);

        // R7: paired mode over all nibble pairs, with gaps and a pairing restart
        cur_req = "R7"; mode = 2'd2;
        for (int i = 0; i < 256; i++) begin
            pix(4'(i >> 4));
            if (i % 3 == 0) idle(1);
            pix(4'(i & 15));
        end
        pix(4'd9);
        idle(1); mode = 2'd1; idle(3); mode = 2'd2;
        pix(4'd3); pix(4'd12);
        idle(12);

        // R8: direct bytes while the table is being rewritten
        cur_req = "R8"; mode = 2'd3;
        for (int b = 0; b < 256; b++) begin
            @(negedge clk);
            in_valid = 1'b1; pix_raw = 8'(b);
            lut_we = 1'b1; lut_waddr = 4'(b); lut_wdata = 6'((b * 7) & 63);
        end
        idle(12);

        // R9: isolated pixels, output exactly two edges later
        cur_req = "R9"; mode = 2'd1; hi_bits = 2'd3;
        for (int n = 0; n < 16; n++) begin pix(4'(n)); idle(3); end
        idle(12);

        // R10: every panning setting, plus a change mid-stream
        cur_req = "R10";
        for (int p = 0; p < 8; p++) begin
            pan = 3'(p); idle(10);
            for (int n = 0; n < 20; n++) pix(4'(n * 5));
            idle(10);
        end
        pan = 3'd5; mode = 2'd3;
        for (int n = 0; n < 12; n++) begin @(negedge clk); in_valid = 1'b1; pix_raw = 8'(n * 19); end
        idle(12);
        pan = 3'd0;
        idle(10);

        // R11: write colliding with the lookup of the same entry
        cur_req = "R11"; mode = 2'd1; hi_bits = 2'd0;
        wr(4'd5, 6'd10);
        idle(3);
        pix(4'd5);
        @(negedge clk); in_valid = 1'b1; pix_nib = 4'd5; lut_we = 1'b1; lut_waddr = 4'd5; lut_wdata = 6'd33;
        pix(4'd5);
        idle(12);

        finish_run();
    end
endmodule